// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Lock Monitor

This block holds one shared lock word and a reservation monitor for a set of requesters that reach it over a single arbitrated bus. Each requester may issue a plain load, a load-linked, a plain store or a store-conditional. A round-robin arbiter grants the bus to exactly one requester per cycle. The transaction completes on the next clock edge, and a registered response (valid, read data, success flag) follows one cycle after the grant.

A load-linked returns the lock word and arms the reservation of the requester that issued it. A store-conditional writes only if that reservation is still armed. Every write that reaches the lock word disarms the reservations of all other requesters, which stands in for the invalidation of their cached copies. Because of this, after a release (a store of 0) a group of contenders that each saw 0 through a load-linked race with store-conditionals of 1. Only the one the arbiter serves first succeeds, and the rest get a failure status.

Each requester has its own reservation state machine with two states, `RSV_IDLE` and `RSV_ARMED`:
- `RSV_IDLE` goes to `RSV_ARMED` on that requester's own granted load-linked ("arm").
- `RSV_ARMED` stays armed on its own load-linked ("re-arm") and on its own plain load.
- `RSV_ARMED` returns to `RSV_IDLE` in three cases: on its own store ("self-clear"), on its own store-conditional whether it passes or fails ("consume"), and on any write by another requester ("snoop-clear").

Top module: `ll_sc_lock_monitor`

## Requirements
- R1: After reset the lock word is 0, no reservation is armed, and `rsp_vld` is all zero.
- R2: `gnt` is combinational. At most one bit is set, and only for a requester whose `req` is high. The search starts at the requester after the last one granted (index 0 after reset) and goes upward, wrapping around.
- R3: One cycle after a grant, `rsp_vld` equals that grant and `rsp_data` holds the lock value from before the transaction.
- R4: Operation code 1 (load-linked) arms the requester's reservation. A second load-linked from the same requester keeps it armed.
- R5: Operation code 3 (store-conditional) from a requester with an armed reservation writes its `wdata` into the lock word and returns `rsp_ok` = 1.
- R6: A store-conditional from a requester without an armed reservation fails with `rsp_ok` = 0 and leaves the lock word unchanged, whatever the lock word holds.
- R7: Every write to the lock word (code 2, or a passing code 3) disarms the reservations of all other requesters. Among racing store-conditionals only the first one served passes.
- R8: A requester's own store-conditional, passing or failing, disarms its own reservation. So does its own store (code 2).
- R9: Operation code 0 (plain load) returns the lock word and changes no reservation.
- R10: `rsp_ok` is 1 only in the response to a passing store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_REQ | Bus request, one bit per requester, held until granted |
| op | input | 2*N_REQ | Operation code per requester (bits 2i+1:2i): 0 load, 1 load-linked, 2 store, 3 store-conditional |
| wdata | input | N_REQ*WORD_W | Write data per requester (bits WORD_W*i upward) |
| gnt | output | N_REQ | One-hot grant for the current cycle |
| rsp_vld | output | N_REQ | One-hot response valid, one cycle after the grant |
| rsp_data | output | WORD_W | Lock word value before the responded transaction |
| rsp_ok | output | 1 | Store-conditional success flag |

## Verification
The grant is due in the same cycle as the request, so the bench reads it one time unit after it drives inputs at the falling edge. It compares that grant with the round-robin order it models itself. The response is due exactly one rising edge after the grant. The driver queues the expected response when it sees the grant, and the monitor compares it at the next falling edge. A response that is missing in that cycle, or one that arrives when nothing is expected, is a mismatch. The lock word and the reservation states are checked only through later responses: load data, and the pass or fail of a later store-conditional.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_LL    = 2'd1,
        OP_STORE = 2'd2,
        OP_SC    = 2'd3
    } op_t;

    typedef enum logic {
        RSV_IDLE  = 1'b0,
        RSV_ARMED = 1'b1
    } rsv_state_t;
endpackage

// File: rtl/lockmon_rr_arb.sv
module lockmon_rr_arb #(
    parameter int N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] gnt
);
    localparam int PW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    logic [PW-1:0] ptr_q;
    int            win_idx;

    always_comb begin
        gnt     = '0;
        win_idx = 0;
        for (int off = 0; off < N_REQ; off++) begin
            int idx;
            idx = (int'(ptr_q) + off) % N_REQ;
            if (gnt == '0 && req[idx]) begin
                gnt[idx] = 1'b1;
                win_idx  = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (|gnt) begin
            ptr_q <= PW'((win_idx + 1) % N_REQ);
        end
    end
endmodule

// File: rtl/lockmon_resv_slot.sv
module lockmon_resv_slot
    import lockmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic own_gnt,
    input  op_t  own_op,
    input  logic peer_write,
    output logic armed
);
    rsv_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSV_IDLE: begin
                if (own_gnt && own_op == OP_LL) state_d = RSV_ARMED;   // arm
            end
            RSV_ARMED: begin
                if (peer_write) begin
                    state_d = RSV_IDLE;                                 // snoop-clear
                end else if (own_gnt) begin
                    unique case (own_op)
                        OP_LL, OP_LOAD: state_d = RSV_ARMED;           // re-arm / keep
                        OP_STORE:       state_d = RSV_IDLE;            // self-clear
                        OP_SC:          state_d = RSV_IDLE;            // consume
                        default:        state_d = RSV_IDLE;
                    endcase
                end
            end
            default: state_d = RSV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        armed = (state_q == RSV_ARMED);
    end
endmodule

// File: rtl/ll_sc_lock_monitor.sv
module ll_sc_lock_monitor
    import lockmon_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int WORD_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_REQ-1:0]        req,
    input  logic [2*N_REQ-1:0]      op,
    input  logic [N_REQ*WORD_W-1:0] wdata,
    output logic [N_REQ-1:0]        gnt,
    output logic [N_REQ-1:0]        rsp_vld,
    output logic [WORD_W-1:0]       rsp_data,
    output logic                    rsp_ok
);
    op_t               op_arr [N_REQ];
    logic [N_REQ-1:0]  armed;
    logic [N_REQ-1:0]  peer_write;
    logic [WORD_W-1:0] lock_q;
    op_t               win_op;
    logic [WORD_W-1:0] win_wdata;
    logic              win_armed;
    logic              sc_pass;
    logic              write_now;

    lockmon_rr_arb #(.N_REQ(N_REQ)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .gnt   (gnt)
    );

    for (genvar i = 0; i < N_REQ; i++) begin : g_slot
        assign op_arr[i]     = op_t'(op[2*i +: 2]);
        assign peer_write[i] = write_now && !gnt[i];

        lockmon_resv_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .own_gnt    (gnt[i]),
            .own_op     (op_arr[i]),
            .peer_write (peer_write[i]),
            .armed      (armed[i])
        );
    end

    always_comb begin
        win_op    = OP_LOAD;
        win_wdata = '0;
        win_armed = 1'b0;
        for (int i = 0; i < N_REQ; i++) begin
            if (gnt[i]) begin
                win_op    = op_arr[i];
                win_wdata = wdata[WORD_W*i +: WORD_W];
                win_armed = armed[i];
            end
        end
        sc_pass   = (|gnt) && win_op == OP_SC && win_armed;
        write_now = ((|gnt) && win_op == OP_STORE) || sc_pass;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         lock_q <= '0;
        else if (write_now) lock_q <= win_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= '0;
            rsp_data <= '0;
            rsp_ok   <= 1'b0;
        end else begin
            rsp_vld  <= gnt;
            rsp_data <= lock_q;
            rsp_ok   <= sc_pass;
        end
    end
endmodule

// File: rtl/ll_sc_lock_monitor_chk.sv
module ll_sc_lock_monitor_chk #(
    parameter int N_REQ  = 4,
    parameter int WORD_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_REQ-1:0]    req,
    input logic [2*N_REQ-1:0]  op,
    input logic [N_REQ-1:0]    gnt,
    input logic [N_REQ-1:0]    rsp_vld,
    input logic                rsp_ok,
    input logic [WORD_W-1:0]   lock_q,
    input logic [N_REQ-1:0]    armed
);
    logic [1:0] g_op;
    logic       g_armed;
    logic       g_any;

    always_comb begin
        g_op    = 2'd0;
        g_armed = 1'b0;
        for (int i = 0; i < N_REQ; i++) begin
            if (gnt[i]) begin
                g_op    = op[2*i +: 2];
                g_armed = armed[i];
            end
        end
        g_any = |gnt;
    end

    assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_gnt_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        g_any |=> (rsp_vld == $past(gnt)));

    assert_ll_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (g_any && g_op == 2'd1) |=> ((armed & $past(gnt)) != '0));

    assert_sc_noresv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (g_any && g_op == 2'd3 && !g_armed) |=> (!rsp_ok && lock_q == $past(lock_q)));

    assert_win_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> (armed == '0));

    assert_ok_only_sc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (g_any && g_op != 2'd3) |=> !rsp_ok);
endmodule

bind ll_sc_lock_monitor ll_sc_lock_monitor_chk #(.N_REQ(N_REQ), .WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .op      (op),
    .gnt     (gnt),
    .rsp_vld (rsp_vld),
    .rsp_ok  (rsp_ok),
    .lock_q  (lock_q),
    .armed   (armed)
);

// File: tb/sim_ll_sc_lock_monitor.sv
`timescale 1ns/1ps
module sim_ll_sc_lock_monitor;
    localparam int N = 4;
    localparam int W = 8;
    localparam logic [1:0] LD = 2'd0, LL = 2'd1, ST = 2'd2, SC = 2'd3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req = '0;
    logic [2*N-1:0] op = '0;
    logic [N*W-1:0] wdata = '0;
    logic [N-1:0]   gnt, rsp_vld;
    logic [W-1:0]   rsp_data;
    logic           rsp_ok;

    always #10 clk = ~clk;

    ll_sc_lock_monitor #(.N_REQ(N), .WORD_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op), .wdata(wdata),
        .gnt(gnt), .rsp_vld(rsp_vld), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
    );

    typedef struct {
        int         id;
        logic [W-1:0] data;
        logic       ok;
        string      tag;
    } exp_t;

    exp_t         sb[$];
    int           compared = 0;
    int           mismatched = 0;
    bit           finished = 0;
    logic [W-1:0] m_lock = '0;
    logic [N-1:0] m_arm = '0;
    int           m_ptr = 0;

    // monitor: compares the response due one edge after each grant
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rsp_vld != '0) begin
                if (sb.size() == 0) begin
                    mismatched++;
                    $display("FAIL R3: unexpected response vld=%b expected none", rsp_vld);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    compared++;
                    if (rsp_vld != N'(1 << e.id) || rsp_data != e.data || rsp_ok != e.ok) begin
                        mismatched++;
                        $display("FAIL %s: vld=%b data=%0d ok=%0d expected vld=%b data=%0d ok=%0d",
                                 e.tag, rsp_vld, rsp_data, rsp_ok, N'(1 << e.id), e.data, e.ok);
                    end
                end
            end else if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                compared++;
                mismatched++;
                $display("FAIL %s (R3): no response, expected vld=%b", e.tag, N'(1 << e.id));
            end
        end
    end

    task automatic txn(input logic [N-1:0] mask, input logic [2*N-1:0] ops,
                       input logic [N*W-1:0] wd, input string tag);
        logic [N-1:0] pending;
        pending = mask;
        while (pending != '0) begin
            int w;
            exp_t e;
            logic [1:0] o;
            logic [W-1:0] d;
            @(negedge clk);
            req = pending; op = ops; wdata = wd;
            #1;
            w = 0;
            for (int off = N - 1; off >= 0; off--) begin
                int idx;
                idx = (m_ptr + off) % N;
                if (pending[idx]) w = idx;
            end
            compared++;
            if (gnt != N'(1 << w)) begin
                mismatched++;
                $display("FAIL R2 (%s): gnt=%b expected %b", tag, gnt, N'(1 << w));
            end
            o = ops[2*w +: 2];
            d = wd[W*w +: W];
            e.id = w; e.data = m_lock; e.ok = 1'b0; e.tag = tag;
            case (o)
                LL: m_arm[w] = 1'b1;
                ST: begin m_lock = d; m_arm = '0; end
                SC: begin
                    if (m_arm[w]) begin e.ok = 1'b1; m_lock = d; m_arm = '0; end
                    else m_arm[w] = 1'b0;
                end
                default: ;
            endcase
            sb.push_back(e);
            m_ptr = (w + 1) % N;
            pending[w] = 1'b0;
        end
        @(negedge clk);
        req = '0;
    endtask

    task automatic one(input int i, input logic [1:0] o, input logic [W-1:0] d, input string tag);
        logic [2*N-1:0] ops;
        logic [N*W-1:0] wd;
        ops = '0; wd = '0;
        ops[2*i +: 2] = o;
        wd[W*i +: W] = d;
        txn(N'(1 << i), ops, wd, tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compared++;
        if (rsp_vld != '0 || gnt != '0) begin
            mismatched++;
            $display("FAIL R1: rsp_vld=%b gnt=%b expected 0 and 0", rsp_vld, gnt);
        end
        one(0, LD, 8'd0, "R1");                 // lock reads 0 after reset
        one(0, SC, 8'd1, "R6");                 // no reservation, lock 0: fails
        one(1, LD, 8'd0, "R6");                 // still 0
        one(1, LL, 8'd0, "R4");
        one(1, SC, 8'd1, "R5");                 // passes
        one(2, LD, 8'd0, "R5");                 // reads 1
        one(1, SC, 8'd0, "R8");                 // consumed: fails
        one(3, LD, 8'd0, "R6");                 // still 1 (lock nonzero case)
        one(1, ST, 8'd0, "R10");                // release, ok 0
        // race after release
        one(0, LL, 8'd0, "R4");
        one(2, LL, 8'd0, "R4");
        one(3, LL, 8'd0, "R4");
        txn(4'b1101, {SC, SC, LD, SC}, {8'd1, 8'd1, 8'd0, 8'd1}, "R7");
        one(1, LD, 8'd0, "R7");                 // spinning requester sees 1
        one(1, ST, 8'd0, "R10");
        // repeated load-linked keeps reservation
        one(2, LL, 8'd0, "R4");
        one(2, LL, 8'd0, "R4");
        one(2, SC, 8'd5, "R4");
        // own store clears own reservation
        one(3, LL, 8'd0, "R8");
        one(3, ST, 8'd0, "R8");
        one(3, SC, 8'd1, "R8");
        // plain loads do not disturb a reservation
        one(0, LL, 8'd0, "R9");
        one(0, LD, 8'd0, "R9");
        one(1, LD, 8'd0, "R9");
        one(0, SC, 8'd7, "R9");
        // failing store-conditional of another does not clear
        one(1, ST, 8'd0, "R7");
        one(0, LL, 8'd0, "R7");
        one(1, SC, 8'd9, "R6");
        one(0, SC, 8'd3, "R7");
        // round-robin order across all requesters
        txn(4'b1111, {LD, LD, LD, LD}, '0, "R2");
        txn(4'b1010, {LD, LD, LD, LD}, '0, "R2");
        repeat (2) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule